// File: doc/BRIEF.md
# Variable Bit-Field Extraction Unit

This unit pulls a field of 1 to 32 bits out of a wider source and returns it as a 32-bit word, either zero-extended or sign-extended. A request gives a signed bit position, a field size and a base descriptor. The base either names a general register or gives a byte address in memory. A register source reads the 64-bit pair made of register n and register n+1. A memory source accepts any signed bit position relative to a byte address. The unit turns that position into an aligned fetch of two consecutive longwords, then shifts and ORs the two words together.

The caller pulses `start_i` while the unit is idle and waits for the one-cycle `done_o` pulse. With that pulse comes either a valid `result_o` or an asserted `fault_o`, which flags a reserved operand. The register file is read through two combinational read ports. Memory is read through a request/acknowledge port that returns one aligned longword per acknowledge.

Top module: `bitfield_extract_unit`

## Requirements
- R1: A size above 32 ends the operation with `done_o` and `fault_o` high in the cycle after `start_i` is sampled. `result_o` is 0 and no memory request is issued.
- R2: A size of 0 ends the operation in the cycle after start, with `result_o` = 0 and `fault_o` low. This holds for any position, and no memory request is made. The R1 size check is applied first.
- R3: If `base_i` bits [AW-1:AW-2] are both 1, the source is register number `base_i[REG_IDX_W-1:0]`. Any other value of those two bits makes `base_i` a byte address in memory.
- R4: For a register source, a position greater than 31, read as unsigned (so every negative position), gives `done_o` and `fault_o` in the cycle after start.
- R5: For a register source, field bit k is bit (pos+k) of the 64-bit value {reg[(n+1) mod 2^REG_IDX_W], reg[n]}. The port `rf_addr_a_o` carries n and `rf_addr_b_o` carries n+1. `done_o` rises in the third cycle after start.
- R6: For a memory source, field bit k is absolute bit (8*base + pos + k) mod 2^(AW+3). Bit j of the longword at aligned address A is absolute bit 8*A + j. The first fetch is at address (base + (pos >>> 3)) with bits [1:0] cleared, and the second fetch is at that address + 4.
- R7: With `sext_i` = 0, result bits at and above the size are 0.
- R8: With `sext_i` = 1, result bits at and above the size copy field bit (size-1). A size of 32 returns the merged field unchanged.
- R9: `mem_req_o` stays high with a stable, longword-aligned `mem_addr_o` until `mem_ack_i` is seen. `mem_data_i` is taken in the acknowledged cycle.
- R10: `done_o` is high for exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an extraction (sampled when idle) |
| pos_i | input | 32 | Signed bit position |
| size_i | input | SIZE_W | Field size in bits |
| base_i | input | AW | Base descriptor: register tag+number or byte address |
| sext_i | input | 1 | 1 = sign-extend, 0 = zero-extend |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Reserved-operand fault, valid with done_o |
| result_o | output | 32 | Extracted field |
| rf_addr_a_o | output | REG_IDX_W | Register file read address, low word |
| rf_addr_b_o | output | REG_IDX_W | Register file read address, high word |
| rf_data_a_i | input | 32 | Register file read data, low word |
| rf_data_b_i | input | 32 | Register file read data, high word |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Aligned longword address |
| mem_ack_i | input | 1 | Memory acknowledge, data valid |
| mem_data_i | input | 32 | Memory read data |

## Verification
The register path is swept over every position from 0 to 31, every size from 1 to 32 and both extension modes. This separates the shift-by-zero case, fields that stay in one register and fields that cross into the next register. Register numbers 0 and the last index show whether n+1 wraps. The memory path is swept over positions from -40 to +40, all four byte offsets of the base and a set of sizes that includes 1, byte-sized, odd and full 32. Mixing negative positions with misaligned bases tells an arithmetic shift from a logical one, and checks that the longword crossing is right. Fault and zero-size cases are combined with out-of-range positions and with both sources, which shows the order in which the checks are applied. A base near address 0 with a negative position tests address wrap-around.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REG,
      ST_MLO,
      ST_MHI,
      ST_MERGE
   } bfx_state_e;

   localparam logic [1:0] REG_TAG = 2'b11;
   localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/bfx_locate.sv
// Turns a signed bit position and a byte address into an aligned fetch
// address and a bit offset inside the first fetched longword.
module bfx_locate #(
   parameter int unsigned AW = 32
) (
   input  logic signed [31:0] pos_i,
   input  logic [AW-1:0]      base_i,
   output logic [AW-1:0]      fetch_addr_o,
   output logic [4:0]         bit_off_o
);
   if (AW < 32 || AW > 64) begin : g_bad_aw
      $error("bfx_locate: AW must be in 32..64");
   end

   logic signed [31:0] byte_step;
   logic [AW-1:0]      byte_off;
   logic [AW-1:0]      sum_addr;

   always_comb begin
      byte_step    = pos_i >>> 3;
      byte_off     = AW'(byte_step);
      sum_addr     = base_i + byte_off;
      fetch_addr_o = {sum_addr[AW-1:2], 2'b00};
      bit_off_o    = {sum_addr[1:0], pos_i[2:0]};
   end
endmodule

// File: rtl/bfx_merge.sv
// Joins two longwords at a bit offset and applies zero or sign extension.
module bfx_merge #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] lo_i,
   input  logic [W-1:0] hi_i,
   input  logic [4:0]   off_i,
   input  logic [5:0]   size_i,
   input  logic         sext_i,
   output logic [W-1:0] field_o
);
   if (W != 32) begin : g_bad_w
      $error("bfx_merge: W must be 32");
   end

   logic [W-1:0] joined;
   logic [W-1:0] hi_part;
   logic [4:0]   top_idx;
   logic         fill;

   always_comb begin
      if (off_i == 5'd0) hi_part = '0;
      else               hi_part = hi_i << (6'd32 - {1'b0, off_i});
      joined  = (lo_i >> off_i) | hi_part;
      top_idx = size_i[4:0] - 5'd1;
      fill    = sext_i & joined[top_idx];
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign field_o[i] = (6'(i) < size_i) ? joined[i] : fill;
   end
endmodule

// File: rtl/bitfield_extract_unit.sv
module bitfield_extract_unit
   import bfx_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned SIZE_W    = 8,
   parameter int unsigned REG_IDX_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic signed [31:0]    pos_i,
   input  logic [SIZE_W-1:0]     size_i,
   input  logic [AW-1:0]         base_i,
   input  logic                  sext_i,
   output logic                  done_o,
   output logic                  fault_o,
   output logic [31:0]           result_o,
   output logic [REG_IDX_W-1:0]  rf_addr_a_o,
   output logic [REG_IDX_W-1:0]  rf_addr_b_o,
   input  logic [31:0]           rf_data_a_i,
   input  logic [31:0]           rf_data_b_i,
   output logic                  mem_req_o,
   output logic [AW-1:0]         mem_addr_o,
   input  logic                  mem_ack_i,
   input  logic [31:0]           mem_data_i
);
   localparam logic [SIZE_W-1:0] MAX_SIZE = SIZE_W'(WORD_W);

   if (SIZE_W < 6) begin : g_bad_size_w
      $error("bitfield_extract_unit: SIZE_W must be at least 6");
   end
   if (REG_IDX_W < 1 || REG_IDX_W > AW - 2) begin : g_bad_reg_w
      $error("bitfield_extract_unit: REG_IDX_W out of range");
   end

   bfx_state_e           state;
   logic [31:0]          lo_q, hi_q;
   logic [4:0]           off_q;
   logic [5:0]           size_q;
   logic                 sext_q;
   logic [AW-1:0]        addr_q;
   logic [REG_IDX_W-1:0] ridx_q;

   logic [AW-1:0]        loc_addr;
   logic [4:0]           loc_off;
   logic [31:0]          merged;
   logic                 is_reg;
   logic                 reg_pos_bad;

   bfx_locate #(.AW(AW)) i_locate (
      .pos_i        (pos_i),
      .base_i       (base_i),
      .fetch_addr_o (loc_addr),
      .bit_off_o    (loc_off)
   );

   bfx_merge #(.W(32)) i_merge (
      .lo_i    (lo_q),
      .hi_i    (hi_q),
      .off_i   (off_q),
      .size_i  (size_q),
      .sext_i  (sext_q),
      .field_o (merged)
   );

   assign is_reg      = (base_i[AW-1:AW-2] == REG_TAG);
   assign reg_pos_bad = ($unsigned(pos_i) > 32'd31);

   assign rf_addr_a_o = ridx_q;
   assign rf_addr_b_o = ridx_q + 1'b1;
   assign mem_req_o   = (state == ST_MLO) || (state == ST_MHI);
   assign mem_addr_o  = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         lo_q     <= '0;
         hi_q     <= '0;
         off_q    <= '0;
         size_q   <= '0;
         sext_q   <= 1'b0;
         addr_q   <= '0;
         ridx_q   <= '0;
         done_o   <= 1'b0;
         fault_o  <= 1'b0;
         result_o <= '0;
      end else begin
         done_o  <= 1'b0;
         fault_o <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start_i) begin
                  size_q <= size_i[5:0];
                  sext_q <= sext_i;
                  if (size_i > MAX_SIZE) begin
                     done_o   <= 1'b1;
                     fault_o  <= 1'b1;
                     result_o <= '0;
                  end else if (size_i == '0) begin
                     done_o   <= 1'b1;
                     result_o <= '0;
                  end else if (is_reg) begin
                     if (reg_pos_bad) begin
                        done_o   <= 1'b1;
                        fault_o  <= 1'b1;
                        result_o <= '0;
                     end else begin
                        ridx_q <= base_i[REG_IDX_W-1:0];
                        off_q  <= pos_i[4:0];
                        state  <= ST_REG;
                     end
                  end else begin
                     addr_q <= loc_addr;
                     off_q  <= loc_off;
                     state  <= ST_MLO;
                  end
               end
            end
            ST_REG: begin
               lo_q  <= rf_data_a_i;
               hi_q  <= rf_data_b_i;
               state <= ST_MERGE;
            end
            ST_MLO: begin
               if (mem_ack_i) begin
                  lo_q   <= mem_data_i;
                  addr_q <= addr_q + AW'(4);
                  state  <= ST_MHI;
               end
            end
            ST_MHI: begin
               if (mem_ack_i) begin
                  hi_q  <= mem_data_i;
                  state <= ST_MERGE;
               end
            end
            ST_MERGE: begin
               result_o <= merged;
               done_o   <= 1'b1;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bfx_checker.sv
module bfx_checker
   import bfx_pkg::*;
#(
   parameter int unsigned AW     = 32,
   parameter int unsigned SIZE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [SIZE_W-1:0] size_i,
   input logic [31:0]       pos_i,
   input logic [1:0]        src_tag,
   input bfx_state_e        state,
   input logic              done_o,
   input logic              fault_o,
   input logic [31:0]       result_o,
   input logic              mem_req_o,
   input logic              mem_ack_i,
   input logic [AW-1:0]     mem_addr_o
);
   logic go;
   assign go = start_i && (state == ST_IDLE);

   assert_big_size_faults_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (go && size_i > SIZE_W'(32)) |=> (done_o && fault_o && result_o == 32'd0 && !mem_req_o));

   assert_zero_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (go && size_i == '0) |=> (done_o && !fault_o && result_o == 32'd0 && !mem_req_o));

   assert_reg_pos_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (go && size_i != '0 && size_i <= SIZE_W'(32) && src_tag == REG_TAG && pos_i > 32'd31)
      |=> (done_o && fault_o));

   assert_second_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_ack_i && state == ST_MLO) |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + AW'(4)));

   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

   assert_addr_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_fault_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (done_o && result_o == 32'd0));
endmodule

bind bitfield_extract_unit bfx_checker #(.AW(AW), .SIZE_W(SIZE_W)) i_bfx_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .size_i     (size_i),
   .pos_i      (pos_i),
   .src_tag    (base_i[AW-1:AW-2]),
   .state      (state),
   .done_o     (done_o),
   .fault_o    (fault_o),
   .result_o   (result_o),
   .mem_req_o  (mem_req_o),
   .mem_ack_i  (mem_ack_i),
   .mem_addr_o (mem_addr_o)
);

// File: tb/test_bitfield_extract_unit.sv
module test_bitfield_extract_unit;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int SIZE_W = 8;
   localparam int RIW = 4;
   localparam int WATCHDOG = 190000;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start_i = 1'b0;
   logic signed [31:0]  pos_i = '0;
   logic [SIZE_W-1:0]   size_i = '0;
   logic [AW-1:0]       base_i = '0;
   logic                sext_i = 1'b0;
   logic                done_o, fault_o;
   logic [31:0]         result_o;
   logic [RIW-1:0]      rf_addr_a_o, rf_addr_b_o;
   logic [31:0]         rf_data_a_i, rf_data_b_i;
   logic                mem_req_o;
   logic [AW-1:0]       mem_addr_o;
   logic                mem_ack_i = 1'b0;
   logic [31:0]         mem_data_i = '0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] reg_val(input logic [RIW-1:0] n);
      return (32'(n) * 32'h0123_4567) ^ 32'hA5C3_96E1;
   endfunction

   function automatic logic [31:0] mem_val(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   assign rf_data_a_i = reg_val(rf_addr_a_o);
   assign rf_data_b_i = reg_val(rf_addr_b_o);

   bitfield_extract_unit #(.AW(AW), .SIZE_W(SIZE_W), .REG_IDX_W(RIW)) i_bitfield_extract_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .pos_i(pos_i), .size_i(size_i),
      .base_i(base_i), .sext_i(sext_i), .done_o(done_o), .fault_o(fault_o),
      .result_o(result_o), .rf_addr_a_o(rf_addr_a_o), .rf_addr_b_o(rf_addr_b_o),
      .rf_data_a_i(rf_data_a_i), .rf_data_b_i(rf_data_b_i), .mem_req_o(mem_req_o),
      .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i), .mem_data_i(mem_data_i)
   );

   // memory responder with address-dependent wait states
   initial begin
      int wait_cnt;
      wait_cnt = 0;
      forever begin
         @(negedge clk);
         if (mem_ack_i) mem_ack_i = 1'b0;
         else if (mem_req_o) begin
            if (wait_cnt >= int'((mem_addr_o >> 2) % 3)) begin
               mem_ack_i  = 1'b1;
               mem_data_i = mem_val(mem_addr_o);
               wait_cnt   = 0;
            end else wait_cnt++;
         end
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            summary();
         end
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // independent model: {fault, result}
   function automatic logic [32:0] model(input logic [31:0] base, input logic signed [31:0] pos,
                                         input logic [7:0] size, input logic sx);
      logic [31:0] f;
      logic        topb;
      f = '0;
      if (size > 8'd32) return {1'b1, 32'd0};
      if (size == 8'd0) return {1'b0, 32'd0};
      if (base[31:30] == 2'b11) begin
         logic [63:0] pair;
         logic [RIW-1:0] n;
         if ($unsigned(pos) > 32'd31) return {1'b1, 32'd0};
         n    = base[RIW-1:0];
         pair = {reg_val(n + 1'b1), reg_val(n)} >> pos[4:0];
         for (int k = 0; k < int'(size); k++) f[k] = pair[k];
      end else begin
         for (int k = 0; k < int'(size); k++) begin
            longint bb;
            logic [31:0] wa;
            logic [31:0] wd;
            bb = longint'(base) * 8 + longint'(pos) + longint'(k);
            bb = bb & 64'h7_FFFF_FFFF;
            wa = 32'((bb >> 5) << 2);
            wd = mem_val(wa);
            f[k] = wd[bb[4:0]];
         end
      end
      topb = f[size - 8'd1];
      for (int k = int'(size); k < 32; k++) f[k] = sx & topb;
      return {1'b0, f};
   endfunction

   task automatic run(input logic [31:0] base, input logic signed [31:0] pos,
                      input logic [7:0] size, input logic sx, input string req,
                      output int lat, output bit saw_req);
      logic [32:0] exp;
      @(negedge clk);
      base_i = base; pos_i = pos; size_i = size; sext_i = sx; start_i = 1'b1;
      lat = 0; saw_req = 0;
      forever begin
         @(negedge clk);
         start_i = 1'b0;
         lat++;
         if (mem_req_o) saw_req = 1;
         if (done_o) break;
         if (lat > 60) break;
      end
      exp = model(base, pos, size, sx);
      check(req, {31'd0, done_o, fault_o, result_o}, {31'd0, 1'b1, exp});
      @(negedge clk);
      if (done_o) check("R10 done pulse", {63'd0, done_o}, 64'd0);
   endtask

   initial begin
      int lat;
      bit sr;
      repeat (3) @(negedge clk);
      check("R10 reset state", {61'd0, done_o, fault_o, mem_req_o}, 64'd0);
      rst_n = 1'b1;

      // R1: oversized fields, both sources
      run(32'h0000_1000, 5, 8'd33, 0, "R1 size 33 mem", lat, sr);
      check("R1 no mem request", {63'd0, sr}, 64'd0);
      check("R1 latency", 64'(lat), 64'd1);
      run(32'hC000_0003, 0, 8'd255, 1, "R1 size 255 reg", lat, sr);

      // R2: size zero ignores position and source
      run(32'h0000_1003, -77, 8'd0, 1, "R2 size 0 mem", lat, sr);
      check("R2 no mem request", {63'd0, sr}, 64'd0);
      check("R2 latency", 64'(lat), 64'd1);
      run(32'hC000_0001, 40, 8'd0, 0, "R2 size 0 beats reg pos fault", lat, sr);

      // R4: register position faults
      run(32'hC000_0002, 32, 8'd4, 0, "R4 reg pos 32", lat, sr);
      run(32'hC000_0002, 1000, 8'd1, 0, "R4 reg pos 1000", lat, sr);
      run(32'hC000_0002, -1, 8'd4, 1, "R4 reg pos -1", lat, sr);

      // R3/R5/R7/R8: register sweep
      for (int p = 0; p < 32; p++)
         for (int s = 1; s <= 32; s++)
            for (int x = 0; x < 2; x++) begin
               run(32'hC000_0000 | 32'((p + s) % 16), p, 8'(s), x[0],
                   x ? "R5 R8 reg sext" : "R5 R7 reg zext", lat, sr);
               if (p == 0 && s == 1) begin
                  check("R5 reg latency", 64'(lat), 64'd3);
                  check("R3 reg source makes no mem request", {63'd0, sr}, 64'd0);
               end
            end
      run(32'hC000_000F, 20, 8'd32, 1, "R5 register index wraps", lat, sr);
      run(32'h8000_000F, 3, 8'd12, 0, "R3 tag 10 is memory", lat, sr);
      check("R3 tag 10 requests memory", {63'd0, sr}, 64'd1);
      run(32'h4000_0002, -9, 8'd20, 1, "R3 tag 01 is memory", lat, sr);

      // R6/R7/R8/R9: memory sweep
      begin
         int sizes[7] = '{1, 5, 8, 13, 24, 31, 32};
         for (int p = -40; p <= 40; p++)
            for (int si = 0; si < 7; si++)
               for (int b = 0; b < 4; b++)
                  for (int x = 0; x < 2; x++)
                     run(32'h0000_2000 + 32'(b), p, 8'(sizes[si]), x[0],
                         x ? "R6 R8 R9 mem sext" : "R6 R7 R9 mem zext", lat, sr);
      end
      run(32'h0000_0002, -64, 8'd32, 0, "R6 negative wrap", lat, sr);
      run(32'hBFFF_FFFF, 30, 8'd31, 1, "R6 high address", lat, sr);

      summary();
   end
endmodule